// File: doc/BRIEF.md
# Periodic Wake Timer with Cross-Domain Reload

This block produces a regular interrupt from a slow timer clock, with its period set from a faster bus clock. Software writes a 10-bit compare value on the bus side. A legal value is parked in a holding register, and a toggle is sent into the timer domain. The timer domain samples the holding register only once it has seen the toggle, so a multi-bit value is never caught while it is changing.

When the active value is nonzero, a counter in the timer domain runs from zero up to the value and then wraps. Each wrap gives a one-cycle tick. The tick is sent back to the bus domain as a toggle, where it sets a sticky interrupt flag; software clears the flag by writing one. A value of zero stops the timer. A nonzero value below four is refused: it changes nothing and sets a sticky configuration-error bit. Every accepted write restarts the count from zero when it arrives in the timer domain. Because of the two synchronizer stages, the first tick after a write comes later than the steady period.

Top module: `periodic_wake_timer`

## Requirements
- R1: After reset, `irq_flag`, `cfg_err` and `tmr_tick` are 0 and the timer is stopped.
- R2: While the active compare value is 0, `tmr_tick` stays low, so `irq_flag` is never set.
- R3: With active compare value V (V >= 4), consecutive `tmr_tick` pulses are exactly V+1 `tclk` cycles apart, and each pulse lasts one `tclk` cycle.
- R4: A write of a value from 1 to 3 sets `cfg_err`. The running period and the active value stay unchanged. `cfg_err` stays set until reset.
- R5: 4 is the smallest accepted nonzero value, and every value from 4 to 1023 is accepted without setting `cfg_err`.
- R6: Count the first `tclk` rising edge after the `bclk` edge that takes an accepted write V as edge 1. With the default two synchronizer stages, the first tick is on edge V+4. This is the steady V+1, plus two synchronizer edges, plus one load edge.
- R7: An accepted write restarts the count from zero when it is loaded, whatever the old count was. The first tick after the write follows the R6 timing even when the old count was larger than V.
- R8: Each tick sets `irq_flag` within 4 `bclk` cycles. A tick arriving in the same cycle as a clear wins.
- R9: `irq_flag` stays set until `irq_w1c` is pulsed high; that pulse clears it in the next `bclk` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst_n | input | 1 | Bus-domain reset, active low |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | 10 | Compare value to write |
| irq_w1c | input | 1 | Writing one clears the interrupt flag |
| irq_flag | output | 1 | Sticky interrupt flag, bus domain |
| cfg_err | output | 1 | Sticky illegal-value status, bus domain |
| tclk | input | 1 | Timer clock |
| trst_n | input | 1 | Timer-domain reset, active low |
| tmr_tick | output | 1 | One-cycle tick in the timer domain |

## Verification
The assertions assume two things about software:
- It waits until one accepted write has been loaded in the timer domain (about three `tclk` cycles) before it writes again, because the holding register is sampled only after the toggle arrives.
- The two clocks are unrelated, but neither clock's rising edge lands on the other's.

The stimulus meets both. The bench spaces every write by at least one full timer period, or by a measured wait. Its clock phases put every `tclk` rising edge between a `bclk` falling edge and the next `bclk` rising edge. Writes are timed just after an observed tick, so an old tick cannot fall inside the window in which a new value is being loaded.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

  // A compare value is accepted when it disables the timer or meets the minimum.
  function automatic logic cmp_accept(input int unsigned v, input int unsigned minv);
    return (v == 0) || (v >= minv);
  endfunction

  // The tick fires when the counter has reached a nonzero active value.
  function automatic logic cnt_hit(input int unsigned cnt, input int unsigned val);
    return (val != 0) && (cnt == val);
  endfunction

  // Steady spacing between ticks, in timer cycles.
  function automatic int unsigned period_cycles(input int unsigned val);
    return val + 1;
  endfunction

endpackage

// File: rtl/pwt_sync_bit.sv
module pwt_sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sh[0] <= 1'b0;
          else        sh[0] <= d;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sh[i] <= 1'b0;
          else        sh[i] <= sh[i-1];
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pwt_bus_cfg.sv
module pwt_bus_cfg
  import pwt_pkg::*;
#(
  parameter int CMP_W   = 10,
  parameter int MIN_CMP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CMP_W-1:0] wdata,
  output logic [CMP_W-1:0] hold_val,
  output logic             req_tgl,
  output logic             cfg_err
);
  logic wr_ok;
  logic wr_bad;

  assign wr_ok  = we &&  cmp_accept(32'(wdata), MIN_CMP);
  assign wr_bad = we && !cmp_accept(32'(wdata), MIN_CMP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_val <= '0;
      req_tgl  <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      if (wr_ok) begin
        hold_val <= wdata;
        req_tgl  <= ~req_tgl;
      end
      if (wr_bad) cfg_err <= 1'b1;
    end
  end

  // R4: a refused write sends nothing across and changes nothing held
  p_reject_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> ($stable(req_tgl) && $stable(hold_val)));

  // R4: the error bit is sticky
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  // R5: a legal write is announced to the timer domain
  p_accept_sends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> !$stable(req_tgl));
endmodule

// File: rtl/pwt_tmr_core.sv
module pwt_tmr_core
  import pwt_pkg::*;
#(
  parameter int CMP_W       = 10,
  parameter int MIN_CMP     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_tgl,
  input  logic [CMP_W-1:0] hold_val,
  output logic             tick,
  output logic             tick_tgl
);
  logic             req_s;
  logic             req_seen;
  logic             load;
  logic             hit;
  logic [CMP_W-1:0] active_val;
  logic [CMP_W-1:0] cnt;

  pwt_sync_bit #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(req_tgl), .q(req_s)
  );

  assign load = req_s ^ req_seen;
  assign hit  = cnt_hit(32'(cnt), 32'(active_val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_seen   <= 1'b0;
      active_val <= '0;
      cnt        <= '0;
      tick       <= 1'b0;
      tick_tgl   <= 1'b0;
    end else begin
      req_seen <= req_s;
      if (load) begin
        active_val <= hold_val;
        cnt        <= '0;
        tick       <= 1'b0;
      end else if (active_val == '0) begin
        cnt  <= '0;
        tick <= 1'b0;
      end else if (hit) begin
        cnt      <= '0;
        tick     <= 1'b1;
        tick_tgl <= ~tick_tgl;
      end else begin
        cnt  <= cnt + CMP_W'(1);
        tick <= 1'b0;
      end
    end
  end

  // R2: a stopped timer never ticks
  p_idle_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active_val == '0) |=> !tick);

  // R3: the counter never passes the active value
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_val != '0) |-> (cnt <= active_val));

  // R3: ticks last one cycle and are never back to back
  p_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R5: only legal values ever become active
  p_active_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active_val == '0) || (32'(active_val) >= MIN_CMP));

  // R7: a load restarts the count from zero
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == '0));
endmodule

// File: rtl/pwt_irq_flag.sv
module pwt_irq_flag #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_tgl,
  input  logic w1c,
  output logic flag
);
  logic tgl_s;
  logic tgl_seen;
  logic irq_set;

  pwt_sync_bit #(.STAGES(SYNC_STAGES)) u_tick_sync (
    .clk(clk), .rst_n(rst_n), .d(tick_tgl), .q(tgl_s)
  );

  assign irq_set = tgl_s ^ tgl_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_seen <= 1'b0;
      flag     <= 1'b0;
    end else begin
      tgl_seen <= tgl_s;
      if (irq_set)  flag <= 1'b1;
      else if (w1c) flag <= 1'b0;
    end
  end

  // R8: an arriving tick sets the flag, even against a clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> flag);

  // R9: a clear without a coincident tick empties the flag
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c && !irq_set) |=> !flag);

  // R9: without a clear the flag holds
  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !w1c) |=> flag);
endmodule

// File: rtl/periodic_wake_timer.sv
module periodic_wake_timer #(
  parameter int CMP_W       = 10,
  parameter int MIN_CMP     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             bclk,
  input  logic             brst_n,
  input  logic             cmp_we,
  input  logic [CMP_W-1:0] cmp_wdata,
  input  logic             irq_w1c,
  output logic             irq_flag,
  output logic             cfg_err,
  input  logic             tclk,
  input  logic             trst_n,
  output logic             tmr_tick
);
  logic [CMP_W-1:0] hold_val;
  logic             req_tgl;
  logic             tick_tgl;

  pwt_bus_cfg #(.CMP_W(CMP_W), .MIN_CMP(MIN_CMP)) u_cfg (
    .clk(bclk), .rst_n(brst_n), .we(cmp_we), .wdata(cmp_wdata),
    .hold_val(hold_val), .req_tgl(req_tgl), .cfg_err(cfg_err)
  );

  pwt_tmr_core #(.CMP_W(CMP_W), .MIN_CMP(MIN_CMP), .SYNC_STAGES(SYNC_STAGES)) u_core (
    .clk(tclk), .rst_n(trst_n), .req_tgl(req_tgl), .hold_val(hold_val),
    .tick(tmr_tick), .tick_tgl(tick_tgl)
  );

  pwt_irq_flag #(.SYNC_STAGES(SYNC_STAGES)) u_flag (
    .clk(bclk), .rst_n(brst_n), .tick_tgl(tick_tgl), .w1c(irq_w1c), .flag(irq_flag)
  );
endmodule

// File: tb/tb_periodic_wake_timer.sv
module tb_periodic_wake_timer;
  logic       bclk = 1'b0;
  logic       tclk = 1'b0;
  logic       brst_n = 1'b0;
  logic       trst_n = 1'b0;
  logic       cmp_we = 1'b0;
  logic [9:0] cmp_wdata = '0;
  logic       irq_w1c = 1'b0;
  logic       irq_flag, cfg_err, tmr_tick;
  int         tcyc = 0;
  int         checks = 0;
  int         failures = 0;

  // 250 MHz bus clock; slow timer clock whose rising edges fall between
  // a bclk falling edge and the next bclk rising edge.
  always #2 bclk = ~bclk;
  initial begin #1; forever #16 tclk = ~tclk; end
  always @(posedge tclk) tcyc <= tcyc + 1;

  periodic_wake_timer dut (
    .bclk(bclk), .brst_n(brst_n), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .irq_w1c(irq_w1c), .irq_flag(irq_flag), .cfg_err(cfg_err),
    .tclk(tclk), .trst_n(trst_n), .tmr_tick(tmr_tick)
  );

  localparam int NV = 5;
  localparam int VEC_VAL   [NV] = '{4, 7, 12, 33, 1023};
  localparam int VEC_FIRST [NV] = '{8, 11, 16, 37, 1027};
  localparam int VEC_PER   [NV] = '{5, 8, 13, 34, 1024};

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic bus_write(input int v);
    @(negedge bclk); cmp_we = 1'b1; cmp_wdata = 10'(v);
    @(negedge bclk); cmp_we = 1'b0;
  endtask

  task automatic clear_irq();
    @(negedge bclk); irq_w1c = 1'b1;
    @(negedge bclk); irq_w1c = 1'b0;
  endtask

  // Wait for the next tick; returns the timer edge index, or -1 on timeout.
  task automatic wait_tick(input int limit, output int at);
    at = -1;
    for (int k = 0; k < limit; k++) begin
      @(posedge tclk); #1;
      if (tmr_tick) begin at = tcyc; return; end
    end
  endtask

  task automatic bus_wait(input int n);
    for (int k = 0; k < n; k++) @(negedge bclk);
  endtask

  task automatic do_reset();
    brst_n = 1'b0; trst_n = 1'b0;
    bus_wait(4);
    @(posedge tclk); #1;
    brst_n = 1'b1; trst_n = 1'b1;
    bus_wait(2);
  endtask

  initial begin
    #700000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int e0, t1, t2, n;
    do_reset();

    // R1: reset state
    chk(irq_flag == 0, "R1 irq_flag", irq_flag, 0);
    chk(cfg_err == 0, "R1 cfg_err", cfg_err, 0);
    chk(tmr_tick == 0, "R1 tmr_tick", tmr_tick, 0);
    // R2: stopped from reset, no tick
    wait_tick(60, t1);
    chk(t1 == -1, "R2 no tick after reset", t1, -1);

    // Table walk: R6 first tick, R3 period, R8 flag, R9 clear, R5 accepted
    for (int i = 0; i < NV; i++) begin
      bus_write(VEC_VAL[i]);
      e0 = tcyc;
      wait_tick(2000, t1);
      chk(t1 - e0 == VEC_FIRST[i], "R6 first tick edge", t1 - e0, VEC_FIRST[i]);
      wait_tick(2000, t2);
      chk(t2 - t1 == VEC_PER[i], "R3 period", t2 - t1, VEC_PER[i]);
      wait_tick(2000, t1);
      chk(t1 - t2 == VEC_PER[i], "R3 period repeat", t1 - t2, VEC_PER[i]);
      chk(cfg_err == 0, "R5 legal value accepted", cfg_err, 0);
      bus_wait(5);
      chk(irq_flag == 1, "R8 flag set by tick", irq_flag, 1);
      clear_irq();
      chk(irq_flag == 0, "R9 flag cleared", irq_flag, 0);
      if (i < NV - 1) wait_tick(2000, t1);
    end

    // R4: refused writes while running with 1023
    wait_tick(2000, t1);
    bus_write(2);
    chk(cfg_err == 1, "R4 value 2 refused", cfg_err, 1);
    wait_tick(2000, t2);
    chk(t2 - t1 == 1024, "R4 period unchanged", t2 - t1, 1024);
    bus_write(3);
    bus_write(1);
    wait_tick(2000, t1);
    chk(t1 - t2 == 1024, "R4 period unchanged after 3 and 1", t1 - t2, 1024);
    chk(cfg_err == 1, "R4 cfg_err sticky", cfg_err, 1);

    // R9: flag stays set across ticks without a clear
    chk(irq_flag == 1, "R9 flag held", irq_flag, 1);

    // R7: restart while the old count is far above the new value
    for (int k = 0; k < 200; k++) @(posedge tclk);
    #1;
    bus_write(6);
    e0 = tcyc;
    wait_tick(2000, t1);
    chk(t1 - e0 == 10, "R7 restart first tick", t1 - e0, 10);
    wait_tick(2000, t2);
    chk(t2 - t1 == 7, "R7 period after restart", t2 - t1, 7);

    // R2: zero stops the timer
    bus_write(0);
    for (int k = 0; k < 4; k++) @(posedge tclk);
    clear_irq();
    wait_tick(100, t1);
    chk(t1 == -1, "R2 no tick after zero", t1, -1);
    chk(irq_flag == 0, "R2 flag stays clear", irq_flag, 0);

    // R1: reset again clears sticky state
    do_reset();
    n = 0;
    chk(cfg_err == 0, "R1 cfg_err after reset", cfg_err, n);
    chk(irq_flag == 0, "R1 irq_flag after reset", irq_flag, n);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule